// File: doc/BRIEF.md
# Banked Control Register File for a Two-Wire Bus Controller

This block holds the byte-wide control and status registers of a two-wire serial bus controller. Software reaches it through single-byte reads and writes on a 5-bit offset. The lower part of the map and a few high offsets always reach the same registers. The window from 0x10 to 0x1E shows one of two register sets, and bit 5 of control-3 picks which one. Reads are combinational from the offset. Writes take effect on the clock edge where `wr_en` is high.

Many bits do not simply store what is written. Event flags posted by the transaction sequencer through the `*_set` inputs are cleared by writing a one. Command bits in control-1 never store a value: writing a one to them produces a one-cycle strobe towards the sequencer. The line-level bits of control-3 cannot be written. Clearing the enable bit of control-2 resets the live state and flushes the FIFO counters. The version byte is constant. The FIFO level bytes come from the FIFO, and this block only presents them.

Top module: `ctrl_regbank`

## Requirements
- R1: After a synchronous active-low reset, control-status (0x04) reads 0x10, control-3 (0x0E) reads 0xC0, control-4 (bank 0, 0x1A) reads 0x07, the timeout register (bank 1, 0x14) reads 0x3F, RX FIFO control (bank 1, 0x1E) reads 0x01, every other stored register reads 0x00, and no strobe is high.
- R2: Offsets 0x10–0x1E reach bank 1 when control-3 bit 5 is 1 and bank 0 when it is 0. In bank 0, offsets 0x10–0x17 are eight extra own-address registers. Offsets 0x00–0x0E (even), 0x18, 0x19 and 0x1F reach the same registers in both banks.
- R3: Status (0x02) bits 7, 5, 3 and 2 are set by `st_set` and cleared by writing 1; writing 0 leaves them. Bits 6, 4, 1 and 0 follow `st_set` only and ignore writes. A set in the same cycle as a clear wins.
- R4: In control-1 (0x06), bits 0, 1 and 4 keep their stored value on a write, and the other bits take the written value. Writing 1 to bit 0 raises `start_o`, and writing 1 to bit 1 raises `stop_o`, each for exactly the one cycle after the write.
- R5: Control-3 bits 7 and 6 ignore writes. Its bits 5–0 take the written value.
- R6: A write to control-2 (0x0A) with bit 0 = 0 zeroes control-1, status and control-status, clears the end-of-busy flag (0x19 bit 7) and the FIFO ready flag, and raises `fifo_flush_o` for one cycle. This takes priority over any set input in that cycle.
- R7: Offset 0x1F reads 0x81 at all times. Writes to 0x1F and to control-status-2 (0x18, which reads 0x00) have no effect.
- R8: In the timeout register, a write stores bits 6–0. Bit 7 becomes 0 if written 1 or already 0, and otherwise stays 1. `tmo_set` sets bit 7.
- R9: Reads of undefined offsets (odd offsets below 0x10, 0x1B/0x1D/0x13/0x15–0x17 in bank 1, and others) return 0x00, and writes to them change no register.
- R10: In FIFO control-status (bank 1, 0x10), bit 3 takes the written value and bit 1 (set by `fifo_rdy_set`) is cleared by writing 1. Writing 1 to bit 6 raises `fifo_flush_o` for one cycle and clears bit 1.
- R11: Control-status bit 1 is cleared by writing 1, and its other bits ignore writes. The end-of-busy flag (0x19 bit 7) is set by `eob_set` and cleared by writing 1.
- R12: In RX FIFO control (bank 1, 0x1E), bit 5 becomes 1 when written 1 and keeps its old value when written 0. The other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write this cycle |
| addr | input | 5 | Byte offset for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| st_set | input | 8 | Status bits posted by the sequencer |
| cst_set | input | 8 | Control-status bits posted by the sequencer |
| eob_set | input | 1 | Sets the end-of-busy flag |
| fifo_rdy_set | input | 1 | Sets the FIFO ready flag |
| tmo_set | input | 1 | Sets timeout bit 7 |
| tx_level | input | 8 | TX FIFO status byte shown at bank 1, 0x1A |
| rx_level | input | 8 | RX FIFO status byte shown at bank 1, 0x1C |
| data_o | output | 8 | Data register (0x00) |
| ctl1_o | output | 8 | Control-1 |
| ctl2_o | output | 8 | Control-2 |
| ctl3_o | output | 8 | Control-3 |
| ctl4_o | output | 8 | Control-4 |
| ctl5_o | output | 8 | Control-5 |
| scl_lo_o | output | 8 | Clock low-time register |
| scl_hi_o | output | 8 | Clock high-time register |
| fifo_ctl_o | output | 8 | Bank 0 FIFO control |
| fair_o | output | 8 | Fairness period |
| txctl_o | output | 8 | TX threshold control |
| rxctl_o | output | 8 | RX threshold control |
| tmo_o | output | 8 | Timeout register |
| own_addr_o | output | 80 | Ten own-address bytes, byte 0 = 0x08, byte 1 = 0x0C, bytes 2–9 = bank 0 0x10–0x17 |
| start_o | output | 1 | One-cycle START command strobe |
| stop_o | output | 1 | One-cycle STOP command strobe |
| fifo_flush_o | output | 1 | One-cycle FIFO counter flush strobe |

## Verification
A wrong bank decode shows up in the same cycle as a wrong `rdata` byte, because reads are combinational. It is caught by writing distinct bytes to the same offset in both banks and reading both back. A bit that stores when it should clear or keep shows up on the first read after the offending write, one cycle later. Each special bit is written with both one and zero. A strobe that is late, stuck or missing shows up on `start_o`, `stop_o` or `fifo_flush_o` in the cycle after the write. The disable and FIFO-clear side effects appear on the next read of each affected register.

// File: rtl/regbank_pkg.sv
// Shared types and constants of the banked control register file.
// Assumes an 8-bit data path and a 5-bit byte offset.
package regbank_pkg;
    localparam int DW = 8;
    localparam int AW = 5;

    localparam logic [DW-1:0] VERSION_BYTE = 8'h81;
    localparam logic [DW-1:0] RST_CSTAT    = 8'h10;
    localparam logic [DW-1:0] RST_CTL3     = 8'hC0;
    localparam logic [DW-1:0] RST_CTL4     = 8'h07;
    localparam logic [DW-1:0] RST_TMO      = 8'h3F;
    localparam logic [DW-1:0] RST_RXCTL    = 8'h01;

    localparam logic [DW-1:0] STAT_W1C_MASK  = 8'hAC;
    localparam logic [DW-1:0] CSTAT_W1C_MASK = 8'h02;
    localparam logic [DW-1:0] CTL1_KEEP_MASK = 8'h13;
    localparam logic [DW-1:0] CTL3_KEEP_MASK = 8'hC0;
    localparam int            BANK_BIT       = 5;

    typedef enum logic [4:0] {
        RID_NONE, RID_DATA, RID_STAT, RID_CSTAT, RID_CTL1, RID_OWN0,
        RID_CTL2, RID_OWN1, RID_CTL3, RID_CSTAT2, RID_CSTAT3, RID_VER,
        RID_EXT, RID_CTL4, RID_CTL5, RID_SCLLO, RID_FCTL, RID_SCLHI,
        RID_FCS, RID_FAIR, RID_TXCTL, RID_TMO, RID_TXST, RID_RXST, RID_RXCTL
    } rid_e;
endpackage

// File: rtl/regbank_decode.sv
// Offset decoder: maps a byte offset and the bank bit to a register id.
// Assumes NUM_EXT <= 8 extra address registers at bank 0 offsets 0x10 up.
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int NUM_EXT = 8,
    localparam int EXT_W  = 3
) (
    input  logic [AW-1:0]    addr,
    input  logic             bank,
    output rid_e             rid,
    output logic [EXT_W-1:0] ext_idx
);
    // Decode common offsets first, then the banked window.
    always_comb begin
        rid     = RID_NONE;
        ext_idx = addr[EXT_W-1:0];
        case (addr)
            5'h00: rid = RID_DATA;
            5'h02: rid = RID_STAT;
            5'h04: rid = RID_CSTAT;
            5'h06: rid = RID_CTL1;
            5'h08: rid = RID_OWN0;
            5'h0A: rid = RID_CTL2;
            5'h0C: rid = RID_OWN1;
            5'h0E: rid = RID_CTL3;
            5'h18: rid = RID_CSTAT2;
            5'h19: rid = RID_CSTAT3;
            5'h1F: rid = RID_VER;
            default: begin
                if (bank) begin
                    case (addr)
                        5'h10: rid = RID_FCS;
                        5'h11: rid = RID_FAIR;
                        5'h12: rid = RID_TXCTL;
                        5'h14: rid = RID_TMO;
                        5'h1A: rid = RID_TXST;
                        5'h1C: rid = RID_RXST;
                        5'h1E: rid = RID_RXCTL;
                        default: rid = RID_NONE;
                    endcase
                end else begin
                    case (addr)
                        5'h1A: rid = RID_CTL4;
                        5'h1B: rid = RID_CTL5;
                        5'h1C: rid = RID_SCLLO;
                        5'h1D: rid = RID_FCTL;
                        5'h1E: rid = RID_SCLHI;
                        default: begin
                            if (addr[4:3] == 2'b10 && int'(addr[EXT_W-1:0]) < NUM_EXT)
                                rid = RID_EXT;
                        end
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/regbank_core.sv
// Register storage with per-bit write rules, hardware set inputs,
// disable and flush side effects, command strobes and the read mux.
// Assumes one byte access per cycle, selected by a decoded register id.
module regbank_core
    import regbank_pkg::*;
#(
    parameter int NUM_EXT = 8,
    localparam int EXT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rid_e             rid,
    input  logic [EXT_W-1:0] ext_idx,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    st_set,
    input  logic [DW-1:0]    cst_set,
    input  logic             eob_set,
    input  logic             fifo_rdy_set,
    input  logic             tmo_set,
    input  logic [DW-1:0]    tx_level,
    input  logic [DW-1:0]    rx_level,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    data_q,
    output logic [DW-1:0]    ctl1_q,
    output logic [DW-1:0]    ctl2_q,
    output logic [DW-1:0]    ctl3_q,
    output logic [DW-1:0]    ctl4_q,
    output logic [DW-1:0]    ctl5_q,
    output logic [DW-1:0]    scllo_q,
    output logic [DW-1:0]    sclhi_q,
    output logic [DW-1:0]    fctl_q,
    output logic [DW-1:0]    fair_q,
    output logic [DW-1:0]    txctl_q,
    output logic [DW-1:0]    rxctl_q,
    output logic [DW-1:0]    tmo_q,
    output logic [DW-1:0]    own0_q,
    output logic [DW-1:0]    own1_q,
    output logic [DW-1:0]    ext_q [NUM_EXT],
    output logic             start_q,
    output logic             stop_q,
    output logic             flush_q
);
    logic [DW-1:0] st_q, cst_q;
    logic          eob_q, frdy_q, fien_q;
    logic          wr_disable, wr_flush;
    logic [DW-1:0] st_nxt, cst_nxt;
    logic          eob_nxt, frdy_nxt;

    function automatic logic hit(input logic we, input rid_e r, input rid_e want);
        return we && (r == want);
    endfunction

    // Side-effect conditions of the current write.
    assign wr_disable = hit(wr_en, rid, RID_CTL2) && !wdata[0];
    assign wr_flush   = wr_disable || (hit(wr_en, rid, RID_FCS) && wdata[6]);

    // Next value of event flags: clear by written ones, then set, then disable.
    always_comb begin
        st_nxt   = (st_q & ~(hit(wr_en, rid, RID_STAT) ? (wdata & STAT_W1C_MASK) : '0)) | st_set;
        cst_nxt  = (cst_q & ~(hit(wr_en, rid, RID_CSTAT) ? (wdata & CSTAT_W1C_MASK) : '0)) | cst_set;
        eob_nxt  = (eob_q & !(hit(wr_en, rid, RID_CSTAT3) && wdata[7])) | eob_set;
        frdy_nxt = (frdy_q & !(hit(wr_en, rid, RID_FCS) && wdata[1])) | fifo_rdy_set;
        if (wr_flush)   frdy_nxt = 1'b0;
        if (wr_disable) begin
            st_nxt  = '0;
            cst_nxt = '0;
            eob_nxt = 1'b0;
        end
    end

    // Event flags and one-cycle command strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            cst_q   <= RST_CSTAT;
            eob_q   <= 1'b0;
            frdy_q  <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            st_q    <= st_nxt;
            cst_q   <= cst_nxt;
            eob_q   <= eob_nxt;
            frdy_q  <= frdy_nxt;
            start_q <= hit(wr_en, rid, RID_CTL1) && wdata[0];
            stop_q  <= hit(wr_en, rid, RID_CTL1) && wdata[1];
            flush_q <= wr_flush;
        end
    end

    // Control registers with keep-old, sticky and plain write rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;  ctl1_q  <= '0;  ctl2_q <= '0;  ctl3_q <= RST_CTL3;
            ctl4_q  <= RST_CTL4; ctl5_q <= '0; scllo_q <= '0; sclhi_q <= '0;
            fctl_q  <= '0;  fair_q  <= '0;  txctl_q <= '0; rxctl_q <= RST_RXCTL;
            tmo_q   <= RST_TMO; own0_q <= '0; own1_q <= '0; fien_q <= 1'b0;
        end else begin
            if (wr_en) begin
                case (rid)
                    RID_DATA:  data_q  <= wdata;
                    RID_CTL1:  ctl1_q  <= (ctl1_q & CTL1_KEEP_MASK) | (wdata & ~CTL1_KEEP_MASK);
                    RID_CTL2:  ctl2_q  <= wdata;
                    RID_CTL3:  ctl3_q  <= (ctl3_q & CTL3_KEEP_MASK) | (wdata & ~CTL3_KEEP_MASK);
                    RID_OWN0:  own0_q  <= wdata;
                    RID_OWN1:  own1_q  <= wdata;
                    RID_CTL4:  ctl4_q  <= wdata;
                    RID_CTL5:  ctl5_q  <= wdata;
                    RID_SCLLO: scllo_q <= wdata;
                    RID_SCLHI: sclhi_q <= wdata;
                    RID_FCTL:  fctl_q  <= wdata;
                    RID_FAIR:  fair_q  <= wdata;
                    RID_TXCTL: txctl_q <= wdata;
                    RID_FCS:   fien_q  <= wdata[3];
                    RID_RXCTL: rxctl_q <= {wdata[7:6], wdata[5] | rxctl_q[5], wdata[4:0]};
                    RID_TMO:   tmo_q   <= {!wdata[7] && tmo_q[7], wdata[6:0]};
                    default: ;
                endcase
            end
            if (wr_disable) ctl1_q <= '0;
            if (tmo_set)    tmo_q[7] <= 1'b1;
        end
    end

    // Extra own-address registers, one per bank 0 slot.
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_q[g] <= '0;
            else if (hit(wr_en, rid, RID_EXT) && ext_idx == EXT_W'(g))
                ext_q[g] <= wdata;
        end
    end

    // Combinational read mux; undefined offsets read zero.
    always_comb begin
        case (rid)
            RID_DATA:   rdata = data_q;
            RID_STAT:   rdata = st_q;
            RID_CSTAT:  rdata = cst_q;
            RID_CTL1:   rdata = ctl1_q;
            RID_OWN0:   rdata = own0_q;
            RID_CTL2:   rdata = ctl2_q;
            RID_OWN1:   rdata = own1_q;
            RID_CTL3:   rdata = ctl3_q;
            RID_CSTAT2: rdata = '0;
            RID_CSTAT3: rdata = {eob_q, 7'b0};
            RID_VER:    rdata = VERSION_BYTE;
            RID_EXT:    rdata = ext_q[ext_idx];
            RID_CTL4:   rdata = ctl4_q;
            RID_CTL5:   rdata = ctl5_q;
            RID_SCLLO:  rdata = scllo_q;
            RID_SCLHI:  rdata = sclhi_q;
            RID_FCTL:   rdata = fctl_q;
            RID_FCS:    rdata = {4'b0, fien_q, 1'b0, frdy_q, 1'b0};
            RID_FAIR:   rdata = fair_q;
            RID_TXCTL:  rdata = txctl_q;
            RID_TMO:    rdata = tmo_q;
            RID_TXST:   rdata = tx_level;
            RID_RXST:   rdata = rx_level;
            RID_RXCTL:  rdata = rxctl_q;
            default:    rdata = '0;
        endcase
    end

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        hit(wr_en, rid, RID_STAT) && wdata[7] && !st_set[7] |=> !st_q[7]); // R3
    AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hit(wr_en, rid, RID_CTL1) |=> $stable(ctl1_q[1:0]) && $stable(ctl1_q[4])); // R4
    AST_LVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hit(wr_en, rid, RID_CTL3) |=> $stable(ctl3_q[7:6])); // R5
    AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_disable |=> ctl1_q == '0 && st_q == '0 && cst_q == '0 && !eob_q && flush_q); // R6
    AST_TMO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        hit(wr_en, rid, RID_TMO) && wdata[7] && !tmo_set |=> !tmo_q[7]); // R8
endmodule

// File: rtl/ctrl_regbank.sv
// Top of the banked control register file: decodes the offset with the
// bank bit of control-3 and exposes register values and command strobes.
// Assumes single-byte accesses and a synchronous active-low reset.
module ctrl_regbank
    import regbank_pkg::*;
#(
    parameter int NUM_EXT = 8,
    localparam int NUM_OWN = NUM_EXT + 2,
    localparam int EXT_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [DW-1:0]        st_set,
    input  logic [DW-1:0]        cst_set,
    input  logic                 eob_set,
    input  logic                 fifo_rdy_set,
    input  logic                 tmo_set,
    input  logic [DW-1:0]        tx_level,
    input  logic [DW-1:0]        rx_level,
    output logic [DW-1:0]        data_o,
    output logic [DW-1:0]        ctl1_o,
    output logic [DW-1:0]        ctl2_o,
    output logic [DW-1:0]        ctl3_o,
    output logic [DW-1:0]        ctl4_o,
    output logic [DW-1:0]        ctl5_o,
    output logic [DW-1:0]        scl_lo_o,
    output logic [DW-1:0]        scl_hi_o,
    output logic [DW-1:0]        fifo_ctl_o,
    output logic [DW-1:0]        fair_o,
    output logic [DW-1:0]        txctl_o,
    output logic [DW-1:0]        rxctl_o,
    output logic [DW-1:0]        tmo_o,
    output logic [NUM_OWN*DW-1:0] own_addr_o,
    output logic                 start_o,
    output logic                 stop_o,
    output logic                 fifo_flush_o
);
    rid_e             rid;
    logic [EXT_W-1:0] ext_idx;
    logic [DW-1:0]    own0, own1;
    logic [DW-1:0]    ext [NUM_EXT];

    regbank_decode #(.NUM_EXT(NUM_EXT)) u_dec (
        .addr(addr), .bank(ctl3_o[BANK_BIT]), .rid(rid), .ext_idx(ext_idx)
    );

    regbank_core #(.NUM_EXT(NUM_EXT)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rid(rid), .ext_idx(ext_idx),
        .wdata(wdata), .st_set(st_set), .cst_set(cst_set), .eob_set(eob_set),
        .fifo_rdy_set(fifo_rdy_set), .tmo_set(tmo_set),
        .tx_level(tx_level), .rx_level(rx_level), .rdata(rdata),
        .data_q(data_o), .ctl1_q(ctl1_o), .ctl2_q(ctl2_o), .ctl3_q(ctl3_o),
        .ctl4_q(ctl4_o), .ctl5_q(ctl5_o), .scllo_q(scl_lo_o), .sclhi_q(scl_hi_o),
        .fctl_q(fifo_ctl_o), .fair_q(fair_o), .txctl_q(txctl_o), .rxctl_q(rxctl_o),
        .tmo_q(tmo_o), .own0_q(own0), .own1_q(own1), .ext_q(ext),
        .start_q(start_o), .stop_q(stop_o), .flush_q(fifo_flush_o)
    );

    // Pack the own-address bytes: two common slots, then the bank 0 slots.
    assign own_addr_o[0 +: DW]  = own0;
    assign own_addr_o[DW +: DW] = own1;
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_own
        assign own_addr_o[(g+2)*DW +: DW] = ext[g];
    end

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> $past(wr_en) && $past(addr) == 5'h06); // R4
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 5'h1F |-> rdata == VERSION_BYTE); // R7
endmodule

// File: tb/tb_ctrl_regbank.sv
module tb_ctrl_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  st_set = '0, cst_set = '0;
    logic        eob_set = 1'b0, fifo_rdy_set = 1'b0, tmo_set = 1'b0;
    logic [7:0]  tx_level = 8'h05, rx_level = 8'h0A;
    logic [7:0]  data_o, ctl1_o, ctl2_o, ctl3_o, ctl4_o, ctl5_o, scl_lo_o, scl_hi_o;
    logic [7:0]  fifo_ctl_o, fair_o, txctl_o, rxctl_o, tmo_o;
    logic [79:0] own_addr_o;
    logic        start_o, stop_o, fifo_flush_o;

    int n_chk = 0;
    int n_bad = 0;

    ctrl_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .st_set(st_set), .cst_set(cst_set), .eob_set(eob_set),
        .fifo_rdy_set(fifo_rdy_set), .tmo_set(tmo_set), .tx_level(tx_level),
        .rx_level(rx_level), .data_o(data_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o),
        .ctl3_o(ctl3_o), .ctl4_o(ctl4_o), .ctl5_o(ctl5_o), .scl_lo_o(scl_lo_o),
        .scl_hi_o(scl_hi_o), .fifo_ctl_o(fifo_ctl_o), .fair_o(fair_o),
        .txctl_o(txctl_o), .rxctl_o(rxctl_o), .tmo_o(tmo_o),
        .own_addr_o(own_addr_o), .start_o(start_o), .stop_o(stop_o),
        .fifo_flush_o(fifo_flush_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Row: {req[3:0], write, addr[4:0], data[7:0], expected[7:0]}
    localparam logic [25:0] VEC [NV] = '{
        {4'd1, 1'b0, 5'h0E, 8'h00, 8'hC0},  // R1
        {4'd1, 1'b0, 5'h04, 8'h00, 8'h10},  // R1
        {4'd1, 1'b0, 5'h1A, 8'h00, 8'h07},  // R1
        {4'd7, 1'b0, 5'h1F, 8'h00, 8'h81},  // R7
        {4'd5, 1'b1, 5'h0E, 8'h3F, 8'h00},
        {4'd5, 1'b0, 5'h0E, 8'h00, 8'hFF},  // R5
        {4'd1, 1'b0, 5'h14, 8'h00, 8'h3F},  // R1
        {4'd1, 1'b0, 5'h1E, 8'h00, 8'h01},  // R1
        {4'd2, 1'b0, 5'h1A, 8'h00, 8'h05},  // R2
        {4'd2, 1'b1, 5'h11, 8'h5A, 8'h00},
        {4'd2, 1'b0, 5'h11, 8'h00, 8'h5A},  // R2
        {4'd5, 1'b1, 5'h0E, 8'h00, 8'h00},
        {4'd5, 1'b0, 5'h0E, 8'h00, 8'hC0},  // R5
        {4'd2, 1'b0, 5'h11, 8'h00, 8'h00},  // R2
        {4'd2, 1'b1, 5'h11, 8'h33, 8'h00},
        {4'd2, 1'b0, 5'h11, 8'h00, 8'h33},  // R2
        {4'd2, 1'b1, 5'h0E, 8'h20, 8'h00},
        {4'd2, 1'b0, 5'h0E, 8'h00, 8'hE0},  // R2
        {4'd2, 1'b0, 5'h11, 8'h00, 8'h5A},  // R2
        {4'd7, 1'b1, 5'h1F, 8'h00, 8'h00},
        {4'd7, 1'b0, 5'h1F, 8'h00, 8'h81},  // R7
        {4'd7, 1'b1, 5'h18, 8'hFF, 8'h00},
        {4'd7, 1'b0, 5'h18, 8'h00, 8'h00},  // R7
        {4'd9, 1'b1, 5'h13, 8'h77, 8'h00},
        {4'd9, 1'b0, 5'h13, 8'h00, 8'h00},  // R9
        {4'd9, 1'b1, 5'h01, 8'h55, 8'h00},
        {4'd9, 1'b0, 5'h01, 8'h00, 8'h00},  // R9
        {4'd8, 1'b1, 5'h14, 8'h80, 8'h00},
        {4'd8, 1'b0, 5'h14, 8'h00, 8'h00},  // R8
        {4'd8, 1'b1, 5'h14, 8'h25, 8'h00},
        {4'd8, 1'b0, 5'h14, 8'h00, 8'h25},  // R8
        {4'd12, 1'b1, 5'h1E, 8'h20, 8'h00},
        {4'd12, 1'b0, 5'h1E, 8'h00, 8'h20}, // R12
        {4'd12, 1'b1, 5'h1E, 8'h01, 8'h00},
        {4'd12, 1'b0, 5'h1E, 8'h00, 8'h21}, // R12
        {4'd4, 1'b1, 5'h06, 8'hFC, 8'h00},
        {4'd4, 1'b0, 5'h06, 8'h00, 8'hEC},  // R4
        {4'd6, 1'b1, 5'h0A, 8'h01, 8'h00},
        {4'd6, 1'b0, 5'h0A, 8'h00, 8'h01},  // R6
        {4'd2, 1'b1, 5'h0E, 8'h00, 8'h00},
        {4'd9, 1'b0, 5'h13, 8'h00, 8'h00},  // R9: bank 1 write left slot untouched
        {4'd2, 1'b0, 5'h10, 8'h00, 8'h00},  // R2
        {4'd2, 1'b0, 5'h1D, 8'h00, 8'h00},  // R2
        {4'd7, 1'b0, 5'h18, 8'h00, 8'h00}   // R7
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse_st(input logic [7:0] v);
        @(negedge clk); st_set = v;
        @(negedge clk); st_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", {5'b0, start_o, stop_o, fifo_flush_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
            else rd($sformatf("R%0d row %0d", VEC[i][25:22], i), VEC[i][20:16], VEC[i][7:0]);
        end

        // R3: status flags, W1C on 7/5/3/2, read-only elsewhere
        pulse_st(8'hFF);
        rd("R3", 5'h02, 8'hFF);
        wr(5'h02, 8'hA0); rd("R3", 5'h02, 8'h5F);
        wr(5'h02, 8'h0C); rd("R3", 5'h02, 8'h53);
        wr(5'h02, 8'h53); rd("R3", 5'h02, 8'h53);

        // R4: command strobes last one cycle and leave control-1 unchanged
        wr(5'h06, 8'hED);
        check("R4", {6'b0, start_o, stop_o}, 8'h02);
        rd("R4", 5'h06, 8'hEC);
        @(negedge clk);
        check("R4", {6'b0, start_o, stop_o}, 8'h00);
        wr(5'h06, 8'hEE);
        check("R4", {6'b0, start_o, stop_o}, 8'h01);
        @(negedge clk);
        check("R4", {6'b0, start_o, stop_o}, 8'h00);

        // R11: control-status and end-of-busy flags
        @(negedge clk); cst_set = 8'h02; @(negedge clk); cst_set = '0;
        rd("R11", 5'h04, 8'h12);
        wr(5'h04, 8'hFF); rd("R11", 5'h04, 8'h10);
        @(negedge clk); eob_set = 1'b1; @(negedge clk); eob_set = 1'b0;
        rd("R11", 5'h19, 8'h80);
        wr(5'h19, 8'h80); rd("R11", 5'h19, 8'h00);
        @(negedge clk); eob_set = 1'b1; @(negedge clk); eob_set = 1'b0;
        pulse_st(8'h81);

        // R6: disable zeroes live state and flushes
        wr(5'h0A, 8'h00);
        check("R6", {7'b0, fifo_flush_o}, 8'h01);
        rd("R6", 5'h06, 8'h00);
        rd("R6", 5'h02, 8'h00);
        rd("R6", 5'h04, 8'h00);
        rd("R6", 5'h19, 8'h00);
        @(negedge clk);
        check("R6", {7'b0, fifo_flush_o}, 8'h00);

        // R10: FIFO control-status
        wr(5'h0E, 8'h20);
        @(negedge clk); fifo_rdy_set = 1'b1; @(negedge clk); fifo_rdy_set = 1'b0;
        rd("R10", 5'h10, 8'h02);
        wr(5'h10, 8'h08); rd("R10", 5'h10, 8'h0A);
        check("R10", {7'b0, fifo_flush_o}, 8'h00);
        wr(5'h10, 8'h48);
        check("R10", {7'b0, fifo_flush_o}, 8'h01);
        rd("R10", 5'h10, 8'h08);
        @(negedge clk); fifo_rdy_set = 1'b1; @(negedge clk); fifo_rdy_set = 1'b0;
        wr(5'h10, 8'h0A); rd("R10", 5'h10, 8'h08);

        // R8: timeout bit 7 sticky rule
        @(negedge clk); tmo_set = 1'b1; @(negedge clk); tmo_set = 1'b0;
        rd("R8", 5'h14, 8'hA5);
        wr(5'h14, 8'h05); rd("R8", 5'h14, 8'h85);
        wr(5'h14, 8'h85); rd("R8", 5'h14, 8'h05);

        // R1: reset mid-run restores reset values
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd("R1", 5'h0E, 8'hC0);
        rd("R1", 5'h1A, 8'h07);
        rd("R1", 5'h04, 8'h10);
        rd("R1", 5'h11, 8'h00);
        rd("R1", 5'h1E, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule